// File: doc/BRIEF.md
# Downstream Port Power and Overcurrent Controller

This block sits inside a USB hub and manages the power switches that feed its downstream ports. Hub logic raises a per-port power request; the block turns that into a registered drive level on each power-switch control pin, inverted or not according to a polarity strap. It also watches the active-low fault pins coming back from the switches. Each pin is synchronised and filtered. A fault that survives the filter cuts power and raises a sticky change flag, which software clears with a one-cycle write-one-to-clear pulse.

Four strap values, already latched elsewhere at reset, shape the behaviour. The first picks the pin polarity. The second chooses between switching every port on its own and switching all ports as one group. The third declares that no power switching exists, and then every control pin stays inactive. The last is a per-port mask of battery-charging capability. In grouped mode a fault on any pin is reported once, as a hub-wide event. In per-port mode each fault belongs to its own port.

Top module: `ds_pwr_ctrl`

## Requirements
- R1: While `rst` is high, at every clock edge, each `pwr_ctl` bit is set to its inactive level (equal to `strap_pol_low`), and `bc_en`, `oc_chg_port` and `oc_chg_hub` are 0.
- R2: A port that is on drives its `pwr_ctl` bit to 1 when `strap_pol_low` is 0 and to 0 when it is 1. An off port drives the opposite level. The pin follows a request change one clock edge later.
- R3: With `strap_ganged` = 0, each port is on exactly when its own `pwr_req` bit is 1 (and it holds no fault lock). The other port does not affect it.
- R4: With `strap_ganged` = 1, all ports are on together when any `pwr_req` bit is 1, and all are off when none is.
- R5: With `strap_no_pwrsw` = 1, every `pwr_ctl` bit stays at its inactive level and `bc_en` stays 0, whatever the requests are.
- R6: `oc_n` is active low (0 = fault). It passes through two synchronising flops. A fault is accepted only when the synchronised value stays low for FILT_LEN consecutive cycles. If the raw input is low for FILT_LEN consecutive clock edges, the fault is accepted, and its effects appear FILT_LEN+1 edges after the first low edge. If it is low for FILT_LEN-1 edges, nothing happens. A held-low input is accepted only once.
- R7: With `strap_ganged` = 0, an accepted fault on port i turns off port i at once and sets `oc_chg_port[i]`. Other ports are not affected. Port i stays off while `pwr_req[i]` stays 1, and it can only be turned on again after `pwr_req[i]` has dropped to 0.
- R8: With `strap_ganged` = 1, an accepted fault on any input sets `oc_chg_hub` and turns off all ports. `oc_chg_port` stays 0. Power returns only after all requests have dropped.
- R9: A 1 on `oc_clr_port[i]` or on `oc_clr_hub` clears the matching flag at the next edge. If a new fault is accepted in the same cycle as the clear, the flag is set.
- R10: `bc_en[i]` equals `bc_req[i]` AND `strap_bc_cap[i]` AND (`strap_ganged` = 0) AND (`strap_no_pwrsw` = 0), registered with one edge of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_pol_low | input | 1 | 1 = control pins active low |
| strap_ganged | input | 1 | 1 = all ports switched as one group |
| strap_no_pwrsw | input | 1 | 1 = no power switching present |
| strap_bc_cap | input | NPORT | Per-port battery-charging capability |
| pwr_req | input | NPORT | Per-port power-on request from hub logic |
| bc_req | input | NPORT | Per-port battery-charging request |
| oc_n | input | NPORT | Active-low fault pins from the power switches |
| oc_clr_port | input | NPORT | Write-one-to-clear pulses for the per-port flags |
| oc_clr_hub | input | 1 | Write-one-to-clear pulse for the hub flag |
| pwr_ctl | output | NPORT | Power-switch control pins, polarity applied |
| bc_en | output | NPORT | Battery-charging enable per port |
| oc_chg_port | output | NPORT | Sticky per-port fault change flags |
| oc_chg_hub | output | 1 | Sticky hub-wide fault change flag |

## Verification
The clear pulse from software and the acceptance of a new fault can fall in the same clock cycle. The bench provokes this by counting the filter window exactly: it raises `oc_clr_port` on the cycle whose edge completes the FILT_LEN-th low sample. It then expects the flag to read 1 afterwards, along with the port switched off. A second collision is a fault landing on one port while the other port is on. For that case the bench checks that only the faulty port's pin changes level.

// File: rtl/ds_pwr_pkg.sv
package ds_pwr_pkg;
  typedef enum logic {
    SW_PER_PORT = 1'b0,
    SW_GROUPED  = 1'b1
  } sw_mode_e;
endpackage

// File: rtl/ds_oc_filter.sv
module ds_oc_filter #(
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_n,
  output logic oc_hit
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= oc_n;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || s2_q)
      run_q <= '0;
    else if (run_q != CW'(FILT_LEN))
      run_q <= run_q + 1'b1;
  end

  assign oc_hit = !s2_q && (run_q == CW'(FILT_LEN - 1));

  a_r6_single_accept: assert property (@(posedge clk) disable iff (rst)
    oc_hit |=> !oc_hit);
  a_r6_input_was_low: assert property (@(posedge clk) disable iff (rst)
    oc_hit |-> $past(!oc_n, 2));
endmodule

// File: rtl/ds_oc_flags.sv
module ds_oc_flags #(
  parameter int NPORT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ganged,
  input  logic [NPORT-1:0] hit,
  input  logic [NPORT-1:0] clr_port,
  input  logic             clr_hub,
  output logic [NPORT-1:0] chg_port,
  output logic             chg_hub
);
  import ds_pwr_pkg::*;

  sw_mode_e mode;
  assign mode = sw_mode_e'(ganged);

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_port <= '0;
      chg_hub  <= 1'b0;
    end else begin
      for (int i = 0; i < NPORT; i++)
        chg_port[i] <= (hit[i] && mode == SW_PER_PORT) || (chg_port[i] && !clr_port[i]);
      chg_hub <= ((|hit) && mode == SW_GROUPED) || (chg_hub && !clr_hub);
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_chk
    a_r9_port_set_wins: assert property (@(posedge clk) disable iff (rst)
      (!ganged && hit[g]) |=> chg_port[g]);
    a_r9_port_clear: assert property (@(posedge clk) disable iff (rst)
      (clr_port[g] && !hit[g]) |=> !chg_port[g]);
  end

  a_r8_hub_set: assert property (@(posedge clk) disable iff (rst)
    (ganged && (|hit)) |=> chg_hub);
  a_r9_hub_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_hub && !(ganged && (|hit))) |=> !chg_hub);
endmodule

// File: rtl/ds_pwr_switch.sv
module ds_pwr_switch #(
  parameter int NPORT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pol_low,
  input  logic             ganged,
  input  logic             no_pwrsw,
  input  logic [NPORT-1:0] pwr_req,
  input  logic [NPORT-1:0] hit,
  input  logic [NPORT-1:0] bc_cap,
  input  logic [NPORT-1:0] bc_req,
  output logic [NPORT-1:0] pwr_ctl,
  output logic [NPORT-1:0] bc_en
);
  import ds_pwr_pkg::*;

  sw_mode_e         mode;
  logic [NPORT-1:0] lock_q, lock_d, on_d;
  logic             glock_q, glock_d, any_req;

  assign mode    = sw_mode_e'(ganged);
  assign any_req = |pwr_req;

  always_comb begin
    lock_d  = '0;
    glock_d = 1'b0;
    on_d    = '0;
    if (mode == SW_GROUPED) begin
      glock_d = any_req && (glock_q || (|hit));
      on_d    = {NPORT{any_req && !glock_d}};
    end else begin
      lock_d = pwr_req & (lock_q | hit);
      on_d   = pwr_req & ~lock_d;
    end
    if (no_pwrsw)
      on_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q  <= '0;
      glock_q <= 1'b0;
      pwr_ctl <= {NPORT{pol_low}};
      bc_en   <= '0;
    end else begin
      lock_q  <= lock_d;
      glock_q <= glock_d;
      pwr_ctl <= on_d ^ {NPORT{pol_low}};
      bc_en   <= bc_req & bc_cap & {NPORT{(mode == SW_PER_PORT) && !no_pwrsw}};
    end
  end

  a_r5_no_switch_inactive: assert property (@(posedge clk) disable iff (rst)
    no_pwrsw |=> (pwr_ctl == {NPORT{$past(pol_low)}}));
  a_r4_grouped_equal: assert property (@(posedge clk) disable iff (rst)
    ganged |=> (pwr_ctl == {NPORT{pwr_ctl[0]}}));
  a_r10_bc_gated: assert property (@(posedge clk) disable iff (rst)
    (|bc_en) |-> $past(!ganged && !no_pwrsw));

  for (genvar g = 0; g < NPORT; g++) begin : g_chk
    a_r7_trip_off: assert property (@(posedge clk) disable iff (rst)
      (!ganged && hit[g]) |=> (pwr_ctl[g] == $past(pol_low)));
  end
endmodule

// File: rtl/ds_pwr_ctrl.sv
module ds_pwr_ctrl #(
  parameter int NPORT    = 2,
  parameter int FILT_LEN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap_pol_low,
  input  logic             strap_ganged,
  input  logic             strap_no_pwrsw,
  input  logic [NPORT-1:0] strap_bc_cap,
  input  logic [NPORT-1:0] pwr_req,
  input  logic [NPORT-1:0] bc_req,
  input  logic [NPORT-1:0] oc_n,
  input  logic [NPORT-1:0] oc_clr_port,
  input  logic             oc_clr_hub,
  output logic [NPORT-1:0] pwr_ctl,
  output logic [NPORT-1:0] bc_en,
  output logic [NPORT-1:0] oc_chg_port,
  output logic             oc_chg_hub
);
  logic [NPORT-1:0] hit;

  for (genvar g = 0; g < NPORT; g++) begin : g_filt
    ds_oc_filter #(.FILT_LEN(FILT_LEN)) i_filt (
      .clk    (clk),
      .rst    (rst),
      .oc_n   (oc_n[g]),
      .oc_hit (hit[g])
    );
  end

  ds_pwr_switch #(.NPORT(NPORT)) i_sw (
    .clk      (clk),
    .rst      (rst),
    .pol_low  (strap_pol_low),
    .ganged   (strap_ganged),
    .no_pwrsw (strap_no_pwrsw),
    .pwr_req  (pwr_req),
    .hit      (hit),
    .bc_cap   (strap_bc_cap),
    .bc_req   (bc_req),
    .pwr_ctl  (pwr_ctl),
    .bc_en    (bc_en)
  );

  ds_oc_flags #(.NPORT(NPORT)) i_flags (
    .clk      (clk),
    .rst      (rst),
    .ganged   (strap_ganged),
    .hit      (hit),
    .clr_port (oc_clr_port),
    .clr_hub  (oc_clr_hub),
    .chg_port (oc_chg_port),
    .chg_hub  (oc_chg_hub)
  );
endmodule

// File: tb/test_ds_pwr_ctrl.sv
module test_ds_pwr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 2;
  localparam int FILT = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pol = 1'b0, gang = 1'b0, nosw = 1'b0;
  logic [NP-1:0] cap = '0, req = '0, bcr = '0, ocn = '1, clrp = '0;
  logic          clrh = 1'b0;
  logic [NP-1:0] pwr_ctl, bc_en, chp;
  logic          chh;

  typedef struct {
    int            cyc;
    logic [NP-1:0] pwr;
    logic [NP-1:0] bc;
    logic [NP-1:0] chp;
    logic          chh;
    string         tag;
  } item_t;

  item_t q[$];
  int    cnt = 0, checks = 0, fails = 0;
  bit    done = 0;
  logic [NP-1:0] e_on = '0, e_bc = '0, e_chp = '0;
  logic          e_chh = 1'b0;

  ds_pwr_ctrl #(.NPORT(NP), .FILT_LEN(FILT)) i_ds_pwr_ctrl (
    .clk(clk), .rst(rst), .strap_pol_low(pol), .strap_ganged(gang),
    .strap_no_pwrsw(nosw), .strap_bc_cap(cap), .pwr_req(req), .bc_req(bcr),
    .oc_n(ocn), .oc_clr_port(clrp), .oc_clr_hub(clrh),
    .pwr_ctl(pwr_ctl), .bc_en(bc_en), .oc_chg_port(chp), .oc_chg_hub(chh)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cnt <= cnt + 1;

  // driver: push expectation for the state after the coming edge
  task automatic step(input string tag, input int n = 1);
    for (int k = 0; k < n; k++) begin
      item_t it;
      it.cyc = cnt + 1;
      it.pwr = e_on ^ {NP{pol}};
      it.bc  = e_bc;
      it.chp = e_chp;
      it.chh = e_chh;
      it.tag = tag;
      q.push_back(it);
      @(negedge clk);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].cyc == cnt) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (pwr_ctl !== it.pwr || bc_en !== it.bc || chp !== it.chp || chh !== it.chh) begin
          fails++;
          $display("FAIL %s cyc %0d: got pwr=%b bc=%b chp=%b chh=%b exp pwr=%b bc=%b chp=%b chh=%b",
                   it.tag, cnt, pwr_ctl, bc_en, chp, chh, it.pwr, it.bc, it.chp, it.chh);
        end
      end
    end
  end

  task automatic do_reset(input logic p, input logic g, input logic ns, input logic [NP-1:0] c);
    rst = 1'b1; pol = p; gang = g; nosw = ns; cap = c;
    req = '0; bcr = '0; ocn = '1; clrp = '0; clrh = 1'b0;
    e_on = '0; e_bc = '0; e_chp = '0; e_chh = 1'b0;
    step("R1 reset", 3);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    // ---- per-port mode, active-high pins ----
    do_reset(1'b0, 1'b0, 1'b0, 2'b01);
    req = 2'b01; e_on = 2'b01; step("R2 R3 port0 on");
    req = 2'b11; e_on = 2'b11; step("R3 both on");
    req = 2'b10; e_on = 2'b10; step("R3 port1 only");
    req = 2'b11; e_on = 2'b11; step("R3 both on again");
    bcr = 2'b11; e_bc = 2'b01; step("R10 bc gated by cap", 2);
    ocn = 2'b10; step("R6 short glitch", FILT - 1);
    ocn = 2'b11; step("R6 glitch rejected", 4);
    ocn = 2'b10; step("R6 filter window", FILT + 1);
    e_on = 2'b10; e_chp = 2'b01; step("R6 R7 port0 trip");
    step("R7 lock held while low", 2);
    ocn = 2'b11; step("R7 lock held after release", 3);
    clrp = 2'b01; e_chp = 2'b00; step("R9 clear port0");
    clrp = 2'b00; step("R9 stays clear");
    req = 2'b10; step("R7 drop request");
    req = 2'b11; e_on = 2'b11; step("R7 rearm port0");
    ocn = 2'b01; step("R9 collision window", FILT + 1);
    clrp = 2'b10; e_on = 2'b01; e_chp = 2'b10; step("R9 set wins over clear");
    clrp = 2'b00; ocn = 2'b11; step("R7 port0 unaffected", 2);
    clrp = 2'b10; e_chp = 2'b00; step("R9 clear port1");
    clrp = 2'b00; step("R9 idle");
    // ---- grouped mode, active-low pins ----
    do_reset(1'b1, 1'b1, 1'b0, 2'b11);
    req = 2'b01; e_on = 2'b11; step("R4 R2 grouped on");
    bcr = 2'b11; step("R10 no bc in grouped", 2);
    ocn = 2'b01; step("R8 filter window", FILT + 1);
    e_on = 2'b00; e_chh = 1'b1; step("R8 hub trip");
    ocn = 2'b11; step("R8 lock held", 3);
    clrh = 1'b1; e_chh = 1'b0; step("R9 clear hub");
    clrh = 1'b0; req = 2'b00; step("R8 drop requests");
    req = 2'b10; e_on = 2'b11; step("R4 grouped on via port1");
    // ---- no switching ----
    do_reset(1'b0, 1'b0, 1'b1, 2'b11);
    req = 2'b11; bcr = 2'b11; step("R5 outputs inactive", 3);
    step("R5 idle", 2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule